// File: doc/BRIEF.md
# Peripheral Bus Transfer Observer

This block sits beside an APB bus as a purely passive listener: it has only inputs from the bus and never drives any of them. It samples the select, enable, write strobe, address and both data buses on every rising clock edge and follows each transfer through its two phases. A setup cycle (select high, enable low) fixes the direction and the address. The following sampled cycle must carry enable high to count as the access cycle, which completes the transfer.

For every completed transfer the observer emits a single record for one cycle. The record carries the direction, the address and one data word. That word is the write-data bus for writes and the read-data bus for reads, both taken in the access cycle. A setup cycle that is not followed directly by an enable cycle is a protocol violation. Violations set a sticky flag and advance a saturating counter, and a synchronous clear input resets both. The observer is meant for on-chip tracing and protocol checking of a peripheral bus segment.

Top module: `apb_txn_observer`

## Requirements
- R1: While reset is applied and right after it, rec_valid, rec_write, rec_addr, rec_data, viol_flag and viol_count are all zero.
- R2: A cycle with bus_sel=1 and bus_en=0 is a setup cycle. If bus_en=1 at the next sampled edge, rec_valid is high for exactly the one cycle that follows that edge.
- R3: rec_write is the bus_wr value of the setup cycle (1 = write, 0 = read). A change of bus_wr during the access cycle has no effect on it.
- R4: rec_addr is the bus_addr value of the setup cycle. A change of bus_addr during the access cycle has no effect on it.
- R5: For a write, rec_data is the bus_wdata value of the access cycle.
- R6: For a read, rec_data is the bus_rdata value of the access cycle.
- R7: If bus_en=0 at the edge after a setup cycle, that edge sets viol_flag, adds one to viol_count and produces no record.
- R8: viol_flag stays high until clr_viol=1 is sampled. That edge zeroes both viol_flag and viol_count. A violation at the same edge wins, leaving viol_flag=1 and viol_count=1.
- R9: viol_count stops at its maximum value (255 for the default 8-bit width) and does not wrap.
- R10: A cycle that breaks an expected access by being a setup cycle itself is counted as a violation and also starts a new transfer with its own direction and address.
- R11: bus_en high with no setup cycle directly before it produces neither a record nor a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_viol | input | 1 | Synchronous clear of violation flag and counter |
| bus_sel | input | 1 | Observed peripheral select |
| bus_en | input | 1 | Observed enable |
| bus_wr | input | 1 | Observed write strobe |
| bus_addr | input | AW | Observed address |
| bus_wdata | input | DW | Observed write data |
| bus_rdata | input | DW | Observed read data |
| rec_valid | output | 1 | One-cycle pulse marking a completed transfer record |
| rec_write | output | 1 | Record direction, 1 for write |
| rec_addr | output | AW | Record address |
| rec_data | output | DW | Record data word |
| viol_flag | output | 1 | Sticky protocol violation flag |
| viol_count | output | CW | Saturating violation count |

## Verification
A phase tracker stuck in the wrong state would show up within one cycle of the next setup. Depending on the fault, a record would go missing, an extra record would appear, or a violation would be counted where the bus behaved correctly. A hold register with a bad enable would put an address or direction from the access cycle into the record, which the bench detects by changing those buses during the access cycle. Counter faults appear at the ports as a wrong count after a clear, a failed saturation, or a lost violation when clear and violation arrive together.

// File: rtl/apb_obs_pkg.sv
`timescale 1ns/1ps
package apb_obs_pkg;
  // Phase of the observed transfer
  typedef enum logic [0:0] {
    PH_IDLE   = 1'b0,
    PH_ACCESS = 1'b1
  } phase_e;
endpackage

// File: rtl/apb_obs_rst_sync.sv
`timescale 1ns/1ps
module apb_obs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/apb_obs_phase.sv
`timescale 1ns/1ps
module apb_obs_phase
  import apb_obs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          rec_valid,
  output logic          rec_write,
  output logic [AW-1:0] rec_addr,
  output logic [DW-1:0] rec_data,
  output logic          viol_evt
);
  phase_e        phase_q, phase_d;
  logic          hold_wr_q;
  logic [AW-1:0] hold_addr_q;
  logic          setup_hit, access_hit;
  logic [DW-1:0] data_pick;

  // Next-state and enables
  always_comb begin
    setup_hit  = bus_sel & ~bus_en;
    access_hit = (phase_q == PH_ACCESS) & bus_en;
    viol_evt   = (phase_q == PH_ACCESS) & ~bus_en;
    phase_d    = setup_hit ? PH_ACCESS : PH_IDLE;
    data_pick  = hold_wr_q ? bus_wdata : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // Setup-phase hold registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_wr_q   <= 1'b0;
      hold_addr_q <= '0;
    end else if (setup_hit) begin
      hold_wr_q   <= bus_wr;
      hold_addr_q <= bus_addr;
    end
  end

  // Record registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_valid <= 1'b0;
    else        rec_valid <= access_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_write <= 1'b0;
      rec_addr  <= '0;
      rec_data  <= '0;
    end else if (access_hit) begin
      rec_write <= hold_wr_q;
      rec_addr  <= hold_addr_q;
      rec_data  <= data_pick;
    end
  end
endmodule

// File: rtl/apb_obs_viol.sv
`timescale 1ns/1ps
module apb_obs_viol #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          clr,
  output logic          flag,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          upd_en;
  logic          flag_d;
  logic [CW-1:0] base, count_d;

  always_comb begin
    upd_en  = evt | clr;
    base    = clr ? '0 : count;
    flag_d  = evt | (flag & ~clr);
    count_d = (evt && base != CNT_MAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      count <= '0;
    end else if (upd_en) begin
      flag  <= flag_d;
      count <= count_d;
    end
  end
endmodule

// File: rtl/apb_txn_observer.sv
`timescale 1ns/1ps
module apb_txn_observer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_viol,
  input  logic          bus_sel,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          rec_valid,
  output logic          rec_write,
  output logic [AW-1:0] rec_addr,
  output logic [DW-1:0] rec_data,
  output logic          viol_flag,
  output logic [CW-1:0] viol_count
);
  logic rst_int_n;
  logic viol_evt;

  apb_obs_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  apb_obs_phase #(.AW(AW), .DW(DW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rec_valid (rec_valid),
    .rec_write (rec_write),
    .rec_addr  (rec_addr),
    .rec_data  (rec_data),
    .viol_evt  (viol_evt)
  );

  apb_obs_viol #(.CW(CW)) u_viol (
    .clk   (clk),
    .rst_n (rst_int_n),
    .evt   (viol_evt),
    .clr   (clr_viol),
    .flag  (viol_flag),
    .count (viol_count)
  );
endmodule

// File: rtl/apb_obs_checker.sv
`timescale 1ns/1ps
module apb_obs_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_viol,
  input logic          bus_en,
  input logic          rec_valid,
  input logic          viol_flag,
  input logic [CW-1:0] viol_count
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  // R2
  rec_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(bus_en));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !clr_viol) |=> viol_flag);

  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_count == CNT_MAX && !clr_viol) |=> (viol_count == CNT_MAX));

  // R7
  count_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_count != 0) |-> viol_flag);

  // R7
  no_rec_on_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !$past(viol_flag)) |-> !rec_valid);
endmodule

bind apb_txn_observer apb_obs_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_viol   (clr_viol),
  .bus_en     (bus_en),
  .rec_valid  (rec_valid),
  .viol_flag  (viol_flag),
  .viol_count (viol_count)
);

// File: tb/test_apb_txn_observer.sv
`timescale 1ns/1ps
module test_apb_txn_observer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 8;

  typedef struct {
    bit          wr;
    logic [31:0] a;
    logic [31:0] d;
  } rec_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_viol;
  logic          bus_sel, bus_en, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          rec_valid, rec_write;
  logic [AW-1:0] rec_addr;
  logic [DW-1:0] rec_data;
  logic          viol_flag;
  logic [CW-1:0] viol_count;

  int   checks = 0;
  int   errors = 0;
  rec_t expq[$];
  bit   mon_on = 1'b0;

  always #2 clk = ~clk;

  apb_txn_observer #(.AW(AW), .DW(DW), .CW(CW)) i_apb_txn_observer (
    .clk(clk), .rst_n(rst_n), .clr_viol(clr_viol),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rec_valid(rec_valid), .rec_write(rec_write), .rec_addr(rec_addr),
    .rec_data(rec_data), .viol_flag(viol_flag), .viol_count(viol_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; clr_viol = 1'b0;
  endtask

  // Drives setup then access; pushes the expected record
  task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      input bit disturb);
    rec_t e;
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = wr; bus_addr = a;
    bus_wdata = $urandom; bus_rdata = $urandom;
    @(negedge clk);
    bus_en = 1'b1;
    bus_wdata = wr ? d : $urandom;
    bus_rdata = wr ? $urandom : d;
    if (disturb) begin
      bus_wr = ~wr;
      bus_addr = ~a;
    end
    e.wr = wr; e.a = a; e.d = d;
    expq.push_back(e);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rec_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R11", "unexpected record addr", rec_addr, 0);
        end else begin
          rec_t e;
          e = expq.pop_front();
          chk(rec_write == e.wr, "R3", "rec_write", rec_write, e.wr);
          chk(rec_addr == e.a, "R4", "rec_addr", rec_addr, e.a);
          chk(rec_data == e.d, e.wr ? "R5" : "R6", "rec_data", rec_data, e.d);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_viol = 1'b0;
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!rec_valid && !viol_flag && viol_count == 0 && rec_addr == 0 &&
        rec_data == 0 && !rec_write, "R1", "outputs in reset", viol_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rec_valid && !viol_flag && viol_count == 0 && rec_addr == 0,
        "R1", "outputs after reset", rec_addr, 0);
    mon_on = 1'b1;

    // R2 R3 R4 R5 R6: separated and back-to-back transfers
    xfer(1'b1, 32'h0000_1000, 32'hDEAD_BEEF, 1'b0);
    idle();
    xfer(1'b0, 32'h0000_2004, 32'h1234_5678, 1'b0);
    xfer(1'b1, 32'hFFFF_FFFC, 32'h0000_0001, 1'b1);
    xfer(1'b0, 32'h8000_0000, 32'hA5A5_5A5A, 1'b1);
    idle();
    idle();
    chk(expq.size() == 0, "R2", "records outstanding", expq.size(), 0);
    chk(!viol_flag && viol_count == 0, "R2", "no violation on clean traffic",
        viol_count, 0);

    // R11: enable without setup
    @(negedge clk); bus_sel = 1'b1; bus_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0;
    @(negedge clk);
    chk(!viol_flag && viol_count == 0, "R11", "stray enable count", viol_count, 0);

    // R7: setup with no enable
    @(negedge clk); bus_sel = 1'b1; bus_en = 1'b0; bus_addr = 32'h44;
    idle();
    @(negedge clk);
    chk(viol_flag == 1'b1, "R7", "flag set", viol_flag, 1);
    chk(viol_count == 1, "R7", "count", viol_count, 1);
    repeat (3) idle();
    chk(viol_flag == 1'b1, "R8", "flag sticky", viol_flag, 1);
    @(negedge clk); clr_viol = 1'b1;
    @(negedge clk); clr_viol = 1'b0;
    chk(!viol_flag && viol_count == 0, "R8", "cleared", viol_count, 0);

    // R8: clear and violation at the same edge
    @(negedge clk); bus_sel = 1'b1; bus_en = 1'b0;
    @(negedge clk); bus_sel = 1'b0; clr_viol = 1'b1;
    @(negedge clk); clr_viol = 1'b0;
    chk(viol_flag && viol_count == 1, "R8", "clear vs violation", viol_count, 1);

    // R10: a second setup interrupts the first
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 32'h0000_0100;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h0000_0200;
    @(negedge clk);
    bus_en = 1'b1; bus_wdata = 32'hCAFE_0200; bus_rdata = 32'h0;
    begin
      rec_t e;
      e.wr = 1'b1; e.a = 32'h0000_0200; e.d = 32'hCAFE_0200;
      expq.push_back(e);
    end
    idle();
    idle();
    chk(viol_count == 2, "R10", "restart counted", viol_count, 2);
    chk(expq.size() == 0, "R10", "restarted record seen", expq.size(), 0);

    // R9: saturation
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); bus_sel = 1'b1; bus_en = 1'b0;
      idle();
    end
    @(negedge clk);
    chk(viol_count == 8'hFF, "R9", "saturated count", viol_count, 8'hFF);
    chk(viol_flag == 1'b1, "R9", "flag at saturation", viol_flag, 1);
    @(negedge clk); clr_viol = 1'b1;
    @(negedge clk); clr_viol = 1'b0;
    chk(viol_count == 0, "R8", "clear after saturation", viol_count, 0);

    repeat (3) idle();
    chk(expq.size() == 0, "R2", "final queue empty", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule